// File: doc/BRIEF.md
# Multi-tap Clock Prescaler

This block turns the oscillator clock into a family of slower, power-of-two tick enables for the peripherals of a small controller. A phase counter marks one base tick in every six oscillator clocks; this is one instruction cycle. A 12-bit binary chain advances once per base tick. Each bit of the chain is a tap, and a tap fires a one-cycle enable when its bit goes from 0 to 1. So tap k fires once every 2^(k+1) base ticks.

Five consumers choose their tap independently through a 4-bit code each: timer 1, timer 2, the serial shift clock, the A/D control clock and a clock output pin. The clock output is a square wave with 50% duty, not a pulse. Timer 2 and the A/D clock each have a mode bit that replaces the tap with a synchronized external clock input. In that mode the block emits one enable for every rising edge seen on that input. All outputs are registered and are plain enables in the oscillator clock domain.

Top module: `tick_divider_hub`

## Requirements
- R1: While rst_n is low, every tick output and cko are 0. After rst_n goes high, the phase counter and the chain both start from zero.
- R2: The base tick recurs exactly every 6 clocks, and the chain changes only on a base tick, by +1. With code 1, consecutive pulses are 12 clocks apart.
- R3: Count clock edges from reset release as n = 1, 2, ... and let m = floor((n-1)/6). A consumer with a code c in 1..12 sees its tick high for exactly the cycle after edge n when n = 6m+1 and m mod 2^c = 2^(c-1). Code c selects a ratio of 1/2^c of the base tick; codes 10, 11 and 12 are hex a, b and c.
- R4: The five codes t1_sel, t2_sel, ser_sel, adc_sel and cko_sel act independently. Each output follows only its own code.
- R5: A code of 0 or 13..15 keeps that output at 0: no tick pulses, and cko stays low.
- R6: For a valid cko_sel c, cko during the cycle after edge n equals bit (c-1) of m, where m = floor((n-1)/6). This gives a 50% duty square wave whose period is 6*2^c clocks.
- R7: With t2_ext_en high, t2_tick ignores the tap. It pulses for one cycle in the cycle after the third rising clock edge that follows a 0-to-1 change of t2_ext_clk. When t2_ext_en is low, t2_ext_clk has no effect.
- R8: adc_ext_en and adc_ext_clk steer adc_tick in exactly the way R7 describes for timer 2.
- R9: No tick output is ever high for two consecutive cycles.
- R10: A 1-to-0 change of an external clock input produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| t1_sel | input | 4 | Timer 1 ratio code |
| t2_sel | input | 4 | Timer 2 ratio code |
| ser_sel | input | 4 | Serial shift clock ratio code |
| adc_sel | input | 4 | A/D control clock ratio code |
| cko_sel | input | 4 | Clock output ratio code |
| t2_ext_en | input | 1 | Timer 2 takes the external clock instead of its tap |
| t2_ext_clk | input | 1 | Timer 2 external count clock (asynchronous) |
| adc_ext_en | input | 1 | A/D clock taken from the external input instead of its tap |
| adc_ext_clk | input | 1 | A/D external clock (asynchronous) |
| t1_tick | output | 1 | Timer 1 one-cycle enable |
| t2_tick | output | 1 | Timer 2 one-cycle enable |
| ser_tick | output | 1 | Serial shift one-cycle enable |
| adc_tick | output | 1 | A/D control one-cycle enable |
| cko | output | 1 | Square-wave clock output |

## Verification
The bench keeps a model of the expected output for every cycle, based on the count of clock edges since reset. It drives all twelve codes, including code 12, whose first pulse needs 12,289 clocks; a design that took a tap off by one bit would show a halved or doubled period there. It also checks that the chain wraps cleanly. Invalid codes and external mode are checked cycle by cycle: a design that decoded code 13 as a thirteenth tap, or let the tap leak through in external mode, would show extra pulses. A synchronizer of the wrong depth, or one that detects the falling edge, would shift or double the external pulses.

// File: rtl/tdh_pkg.sv
package tdh_pkg;

  localparam int SEL_W       = 4;
  localparam int N_CONSUMERS = 5;
  localparam int N_EXT       = 2;

  typedef enum int {
    CON_T1  = 0,
    CON_T2  = 1,
    CON_SER = 2,
    CON_ADC = 3,
    CON_CKO = 4
  } consumer_e;

  // A selection code is usable when it names one of the chain taps (1..taps).
  function automatic logic code_ok(input logic [SEL_W-1:0] code, input int taps);
    return (code != '0) && (int'(code) <= taps);
  endfunction

  // Code that picks chain bit k.
  function automatic logic [SEL_W-1:0] code_of_bit(input int k);
    return SEL_W'(k + 1);
  endfunction

endpackage

// File: rtl/tdh_cycle_gen.sv
module tdh_cycle_gen #(
  parameter int DIV = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic base_tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                      phase_q <= phase_q + CW'(1);
  end

  assign base_tick = (phase_q == LAST);
endmodule

// File: rtl/tdh_ripple_chain.sv
module tdh_ripple_chain #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_tick,
  output logic [WIDTH-1:0] count_q,
  output logic [WIDTH-1:0] rise_q
);
  logic [WIDTH-1:0] count_nx;
  logic [WIDTH-1:0] rise_nx;

  assign count_nx = count_q + WIDTH'(1);
  // bits that go 0 -> 1 on this increment
  assign rise_nx  = base_tick ? (~count_q & count_nx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      rise_q  <= '0;
    end else begin
      rise_q <= rise_nx;
      if (base_tick) count_q <= count_nx;
    end
  end
endmodule

// File: rtl/tdh_edge_sync.sv
module tdh_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  output logic rise
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], ext_in};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tdh_tap_select.sv
module tdh_tap_select
  import tdh_pkg::*;
#(
  parameter int TAPS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic [TAPS-1:0]  tap_vec,
  input  logic             ext_en,
  input  logic             ext_pulse,
  output logic             out_q
);
  logic tap_val;
  logic chosen;

  always_comb begin
    tap_val = 1'b0;
    if (code_ok(sel, TAPS)) begin
      for (int k = 0; k < TAPS; k++) begin
        if (sel == code_of_bit(k)) tap_val = tap_vec[k];
      end
    end
  end

  assign chosen = ext_en ? ext_pulse : tap_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= chosen;
  end
endmodule

// File: rtl/tick_divider_hub.sv
module tick_divider_hub
  import tdh_pkg::*;
#(
  parameter int DIV         = 6,
  parameter int TAPS        = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] t1_sel,
  input  logic [SEL_W-1:0] t2_sel,
  input  logic [SEL_W-1:0] ser_sel,
  input  logic [SEL_W-1:0] adc_sel,
  input  logic [SEL_W-1:0] cko_sel,
  input  logic             t2_ext_en,
  input  logic             t2_ext_clk,
  input  logic             adc_ext_en,
  input  logic             adc_ext_clk,
  output logic             t1_tick,
  output logic             t2_tick,
  output logic             ser_tick,
  output logic             adc_tick,
  output logic             cko
);
  logic                   base_tick;
  logic [TAPS-1:0]        count_q;
  logic [TAPS-1:0]        rise_q;
  logic [N_EXT-1:0]       ext_in;
  logic [N_EXT-1:0]       ext_rise;
  logic [SEL_W-1:0]       sel_arr   [N_CONSUMERS];
  logic [TAPS-1:0]        tap_src   [N_CONSUMERS];
  logic [N_CONSUMERS-1:0] ext_en_v;
  logic [N_CONSUMERS-1:0] ext_pulse_v;
  logic [N_CONSUMERS-1:0] out_v;

  tdh_cycle_gen #(.DIV(DIV)) u_cycle (
    .clk       (clk),
    .rst_n     (rst_n),
    .base_tick (base_tick)
  );

  tdh_ripple_chain #(.WIDTH(TAPS)) u_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .base_tick (base_tick),
    .count_q   (count_q),
    .rise_q    (rise_q)
  );

  assign ext_in = {adc_ext_clk, t2_ext_clk};

  for (genvar e = 0; e < N_EXT; e++) begin : g_sync
    tdh_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .ext_in (ext_in[e]),
      .rise   (ext_rise[e])
    );
  end

  assign sel_arr[CON_T1]  = t1_sel;
  assign sel_arr[CON_T2]  = t2_sel;
  assign sel_arr[CON_SER] = ser_sel;
  assign sel_arr[CON_ADC] = adc_sel;
  assign sel_arr[CON_CKO] = cko_sel;

  assign ext_en_v    = {1'b0, adc_ext_en,  1'b0, t2_ext_en,   1'b0};
  assign ext_pulse_v = {1'b0, ext_rise[1], 1'b0, ext_rise[0], 1'b0};

  for (genvar i = 0; i < N_CONSUMERS; i++) begin : g_tap
    if (i == CON_CKO) begin : g_level
      assign tap_src[i] = count_q;
    end else begin : g_pulse
      assign tap_src[i] = rise_q;
    end
    tdh_tap_select #(.TAPS(TAPS)) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (sel_arr[i]),
      .tap_vec   (tap_src[i]),
      .ext_en    (ext_en_v[i]),
      .ext_pulse (ext_pulse_v[i]),
      .out_q     (out_v[i])
    );
  end

  assign t1_tick  = out_v[CON_T1];
  assign t2_tick  = out_v[CON_T2];
  assign ser_tick = out_v[CON_SER];
  assign adc_tick = out_v[CON_ADC];
  assign cko      = out_v[CON_CKO];
endmodule

// File: rtl/tdh_checker.sv
module tdh_checker
  import tdh_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             base_tick,
  input logic [WIDTH-1:0] count_q,
  input logic [N_EXT-1:0] ext_rise,
  input logic [SEL_W-1:0] t1_sel,
  input logic [SEL_W-1:0] cko_sel,
  input logic             t2_ext_en,
  input logic             adc_ext_en,
  input logic             t1_tick,
  input logic             t2_tick,
  input logic             ser_tick,
  input logic             adc_tick,
  input logic             cko
);
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    base_tick |=> !base_tick); // R2
  AST_CHAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    base_tick |=> (count_q == $past(count_q) + WIDTH'(1))); // R2
  AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !base_tick |=> $stable(count_q)); // R2
  AST_BAD_CODE_T1: assert property (@(posedge clk) disable iff (!rst_n)
    !code_ok(t1_sel, WIDTH) |=> !t1_tick); // R5
  AST_BAD_CODE_CKO: assert property (@(posedge clk) disable iff (!rst_n)
    !code_ok(cko_sel, WIDTH) |=> !cko); // R5
  AST_T2_EXT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (t2_ext_en && !ext_rise[0]) |=> !t2_tick); // R7
  AST_ADC_EXT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_ext_en && !ext_rise[1]) |=> !adc_tick); // R8
  AST_SINGLE_T1: assert property (@(posedge clk) disable iff (!rst_n)
    t1_tick |=> !t1_tick); // R9
  AST_SINGLE_SER: assert property (@(posedge clk) disable iff (!rst_n)
    ser_tick |=> !ser_tick); // R9
  AST_SINGLE_T2: assert property (@(posedge clk) disable iff (!rst_n)
    t2_tick |=> !t2_tick); // R9
endmodule

bind tick_divider_hub tdh_checker #(.WIDTH(TAPS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .base_tick  (base_tick),
  .count_q    (count_q),
  .ext_rise   (ext_rise),
  .t1_sel     (t1_sel),
  .cko_sel    (cko_sel),
  .t2_ext_en  (t2_ext_en),
  .adc_ext_en (adc_ext_en),
  .t1_tick    (t1_tick),
  .t2_tick    (t2_tick),
  .ser_tick   (ser_tick),
  .adc_tick   (adc_tick),
  .cko        (cko)
);

// File: tb/tick_divider_hub_test.sv
module tick_divider_hub_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] t1_sel = 4'd1, t2_sel = 4'd1, ser_sel = 4'd1, adc_sel = 4'd1, cko_sel = 4'd1;
  logic       t2_ext_en = 1'b0, t2_ext_clk = 1'b0, adc_ext_en = 1'b0, adc_ext_clk = 1'b0;
  logic       t1_tick, t2_tick, ser_tick, adc_tick, cko;

  int n_checks = 0;
  int n_fail   = 0;
  int edge_n   = 0;
  bit done     = 1'b0;

  // external-edge pipelines kept by the bench (rise recorded at a negedge)
  bit pend2, h2_1, h2_2, h2_3;
  bit penda, ha_1, ha_2, ha_3;
  bit prev_t1, prev_t2, prev_ser, prev_adc;
  int last_t1 = 0;
  int gap_t1  = 0;

  tick_divider_hub uut (
    .clk(clk), .rst_n(rst_n),
    .t1_sel(t1_sel), .t2_sel(t2_sel), .ser_sel(ser_sel), .adc_sel(adc_sel), .cko_sel(cko_sel),
    .t2_ext_en(t2_ext_en), .t2_ext_clk(t2_ext_clk),
    .adc_ext_en(adc_ext_en), .adc_ext_clk(adc_ext_clk),
    .t1_tick(t1_tick), .t2_tick(t2_tick), .ser_tick(ser_tick), .adc_tick(adc_tick), .cko(cko)
  );

  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_n <= 0;
    else        edge_n <= edge_n + 1;
  end

  function automatic bit valid_code(input int c);
    return (c >= 1) && (c <= 12);
  endfunction

  // pulse expected in the cycle after edge n for ratio 1/2^c
  function automatic bit model_pulse(input int n, input int c);
    int m;
    if (!valid_code(c) || n < 7 || ((n - 1) % 6) != 0) return 1'b0;
    m = (n - 1) / 6;
    return (m % (1 << c)) == (1 << (c - 1));
  endfunction

  function automatic bit model_level(input int n, input int c);
    int m;
    if (!valid_code(c) || n < 1) return 1'b0;
    m = (n - 1) / 6;
    return ((m >> (c - 1)) & 1) == 1;
  endfunction

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at edge %0d: got %b expected %b", req, what, edge_n, act, exp);
    end
  endtask

  task automatic check_int(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string tap_tag(input logic [3:0] code);
    return valid_code(int'(code)) ? "R3 R4" : "R5";
  endfunction

  task automatic run(input int cycles, input int per2, input int pera);
    for (int i = 1; i <= cycles; i++) begin
      @(posedge clk);
      @(negedge clk);
      h2_3 = h2_2; h2_2 = h2_1; h2_1 = pend2; pend2 = 1'b0;
      ha_3 = ha_2; ha_2 = ha_1; ha_1 = penda; penda = 1'b0;

      check(tap_tag(t1_sel), "t1_tick", t1_tick, model_pulse(edge_n, int'(t1_sel)));
      if (t2_ext_en) check("R7 R10", "t2_tick ext", t2_tick, h2_3);
      else           check(tap_tag(t2_sel), "t2_tick", t2_tick, model_pulse(edge_n, int'(t2_sel)));
      check(tap_tag(ser_sel), "ser_tick", ser_tick, model_pulse(edge_n, int'(ser_sel)));
      if (adc_ext_en) check("R8 R10", "adc_tick ext", adc_tick, ha_3);
      else            check(tap_tag(adc_sel), "adc_tick", adc_tick, model_pulse(edge_n, int'(adc_sel)));
      check(valid_code(int'(cko_sel)) ? "R6" : "R5", "cko", cko, model_level(edge_n, int'(cko_sel)));

      if (t1_tick)  check("R9", "t1_tick previous cycle", prev_t1, 1'b0);
      if (t2_tick)  check("R9", "t2_tick previous cycle", prev_t2, 1'b0);
      if (ser_tick) check("R9", "ser_tick previous cycle", prev_ser, 1'b0);
      if (adc_tick) check("R9", "adc_tick previous cycle", prev_adc, 1'b0);
      prev_t1 = t1_tick; prev_t2 = t2_tick; prev_ser = ser_tick; prev_adc = adc_tick;

      if (t1_tick) begin
        if (last_t1 > 0) gap_t1 = edge_n - last_t1;
        last_t1 = edge_n;
      end

      if (per2 > 0 && (i % per2) == 0) begin
        if (!t2_ext_clk) pend2 = 1'b1;
        t2_ext_clk = ~t2_ext_clk;
      end
      if (pera > 0 && (i % pera) == 0) begin
        if (!adc_ext_clk) penda = 1'b1;
        adc_ext_clk = ~adc_ext_clk;
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1", "t1_tick in reset", t1_tick, 1'b0);
    check("R1", "t2_tick in reset", t2_tick, 1'b0);
    check("R1", "ser_tick in reset", ser_tick, 1'b0);
    check("R1", "adc_tick in reset", adc_tick, 1'b0);
    check("R1", "cko in reset", cko, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_fast_codes();
    t1_sel = 4'd1; t2_sel = 4'd2; ser_sel = 4'd3; adc_sel = 4'd4; cko_sel = 4'd1;
    run(240, 0, 0);
    check_int("R2", "t1 pulse spacing with code 1", gap_t1, 12);
  endtask

  task automatic t_mid_codes();
    t1_sel = 4'd5; t2_sel = 4'd6; ser_sel = 4'd7; adc_sel = 4'd8; cko_sel = 4'd3;
    run(1700, 0, 0);
  endtask

  task automatic t_bad_codes();
    t1_sel = 4'd0; t2_sel = 4'd13; ser_sel = 4'd14; adc_sel = 4'd15; cko_sel = 4'd0;
    run(300, 0, 0);
    cko_sel = 4'd15;
    run(100, 0, 0);
  endtask

  task automatic t_top_codes();
    t1_sel = 4'd12; t2_sel = 4'd11; ser_sel = 4'd10; adc_sel = 4'd9; cko_sel = 4'd12;
    run(26000, 0, 0);
  endtask

  task automatic t_ext_on();
    t1_sel = 4'd1; t2_sel = 4'd1; ser_sel = 4'd2; adc_sel = 4'd1; cko_sel = 4'd2;
    t2_ext_en = 1'b1; adc_ext_en = 1'b1;
    run(300, 4, 7);
  endtask

  task automatic t_ext_off();
    t2_ext_en = 1'b0; adc_ext_en = 1'b0;
    t2_ext_clk = 1'b0; adc_ext_clk = 1'b0;
    run(200, 3, 5);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung run expected finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_fast_codes();
    t_mid_codes();
    t_bad_codes();
    t_top_codes();
    t_ext_on();
    t_ext_off();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule